// File: doc/BRIEF.md
# PHY Serial Management and Interrupt Unit

This block is the management side of a 10/100 Ethernet PHY. A host steps a slow management clock and shifts frames on a shared bidirectional data line. The block checks each frame against its strapped PHY address and decodes the read or write. It then accesses a small register file: the seven standard registers at addresses 0 to 6, plus two vendor registers for interrupts.

Link-layer event pulses set sticky flags in an interrupt-source register. A mask register selects which flags count, and one aggregated interrupt line goes to a system interrupt controller. A read of the source register returns the flags and clears them. An event that lands on the clearing clock is kept. Every address outside the implemented set reads as all ones.

The management clock and data input are taken into the system clock domain with two-flop synchronizers. Each rising edge of the management clock yields one bit sample.

Top module: `phy_mgmt_top`

## Requirements
- R1: After reset `irq` is low, `mdio_oe` is low, and the interrupt-source and mask registers read zero.
- R2: A frame is at least 32 ones, then start bits 0,1, then opcode 10 (read) or 01 (write), then a 5-bit PHY address, then a 5-bit register address. These fields go MSB first. A 2-bit turnaround and 16 data bits, MSB first, follow. A frame with opcode 00 or 11 changes nothing.
- R3: MDIO is sampled on rising MDC. On a read the block releases MDIO for turnaround bit 1, drives 0 for turnaround bit 2, and then drives data bits 15 down to 0, one per MDC period. Each new bit appears within three system clocks after the rising MDC that ends the previous bit. MDIO is released after the last data bit.
- R4: A frame whose PHY address differs from `phy_addr` is ignored: no register changes and `mdio_oe` stays low.
- R5: Register 0 (control) and register 4 (advertisement) are read-write, with reset values 16'h3000 and 16'h01E1. Registers 1, 2, 3, 5 and 6 are read-only constants: 16'h7809, 16'h0007, 16'hC0F1, 16'h0000 and 16'h0000. Writes to them have no effect.
- R6: Reads of addresses 7 to 28 and 31 return 16'hFFFF, and writes to them have no effect.
- R7: Register 29 is the interrupt source. `event_pulse[i]` sets bit i+1: bit 1 page received, bit 2 parallel-detect fault, bit 3 partner acknowledge, bit 4 link down, bit 5 remote fault, bit 6 negotiation complete, bit 7 energy present. Bit 0 and bits 15:8 read zero, and a set bit stays set until cleared.
- R8: A read of register 29 returns the current flags and clears them.
- R9: The clear takes effect on the third system clock edge after the rising MDC that samples the last register-address bit. An event pulse present on that same edge stays set after the clear.
- R10: Register 30 is the interrupt mask. Bits 7:1 are read-write with reset 0, and bit 0 and bits 15:8 read zero.
- R11: `irq` is high exactly when some source bit is set and its mask bit is set.
- R12: A write to register 29 leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | Management clock from the host |
| mdio_in | input | 1 | Management data as seen on the pad |
| mdio_out | output | 1 | Management data driven by the block |
| mdio_oe | output | 1 | Output enable for `mdio_out` |
| phy_addr | input | 5 | Strapped PHY address |
| event_pulse | input | 7 | Single-cycle event pulses, bit i sets source bit i+1 |
| irq | output | 1 | Aggregated masked interrupt |

## Verification
The bench reads all 32 register addresses, so a decoder that aliases an unimplemented address onto a real register shows up as a value other than all ones. It checks both turnaround bits on every matched read. A slave that drives one bit early or late either collides with the host or shifts the data word by one place.

The bench times an event pulse onto the exact clock of a source read-clear. A design that lets the clear win loses that flag on the next read. The bench also checks that foreign-address and bad-opcode frames leave registers and MDIO untouched, and that masked flags never raise `irq`.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int REG_AW     = 5;
  localparam int REG_DW     = 16;
  localparam int EVT_W      = 7;
  localparam int PRE_LEN    = 32;
  localparam int PRE_CW     = $clog2(PRE_LEN + 1);
  localparam int HDR_BITS   = 12;              // opcode + phy + register
  localparam int TA_FIRST   = HDR_BITS + 1;    // index after first turnaround sample
  localparam int DATA_FIRST = HDR_BITS + 3;    // first data bit index
  localparam int BODY_BITS  = HDR_BITS + 2 + REG_DW;

  localparam logic [REG_AW-1:0] A_CTRL  = 5'd0;
  localparam logic [REG_AW-1:0] A_STAT  = 5'd1;
  localparam logic [REG_AW-1:0] A_ID_HI = 5'd2;
  localparam logic [REG_AW-1:0] A_ID_LO = 5'd3;
  localparam logic [REG_AW-1:0] A_ADV   = 5'd4;
  localparam logic [REG_AW-1:0] A_LPA   = 5'd5;
  localparam logic [REG_AW-1:0] A_EXP   = 5'd6;
  localparam logic [REG_AW-1:0] A_ISRC  = 5'd29;
  localparam logic [REG_AW-1:0] A_IMASK = 5'd30;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  typedef enum logic [1:0] {SMI_PRE, SMI_START, SMI_BODY} smi_state_t;

  typedef struct packed {
    logic [1:0]        op;
    logic [REG_AW-1:0] phy;
    logic [REG_AW-1:0] regad;
  } smi_hdr_t;

  // Place event-wide flag bits at register bits 7:1.
  function automatic logic [REG_DW-1:0] flags_to_reg(input logic [EVT_W-1:0] f);
    logic [REG_DW-1:0] r;
    r = '0;
    r[EVT_W:1] = f;
    return r;
  endfunction

  // Bit driven onto MDIO for body index idx (index counts samples taken).
  function automatic logic smi_drive_bit(input logic [REG_DW-1:0] d,
                                         input logic [4:0] idx);
    if (idx == 5'(TA_FIRST)) return 1'b0;
    return d[5'(BODY_BITS - 1) - idx];
  endfunction

endpackage

// File: rtl/phy_mdc_sync.sv
module phy_mdc_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdio_in,
  output logic sample_stb,
  output logic sample_bit
);
  logic [2:0] mdc_q;
  logic [1:0] dio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q <= '0;
      dio_q <= '1;
    end else begin
      mdc_q <= {mdc_q[1:0], mdc};
      dio_q <= {dio_q[0], mdio_in};
    end
  end

  assign sample_stb = mdc_q[1] & ~mdc_q[2];
  assign sample_bit = dio_q[1];
endmodule

// File: rtl/phy_smi_slave.sv
module phy_smi_slave
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] phy_addr,
  input  logic              sample_stb,
  input  logic              sample_bit,
  input  logic [REG_DW-1:0] rd_data,
  output logic              rd_req,
  output logic              wr_req,
  output logic [REG_AW-1:0] reg_addr,
  output logic [REG_DW-1:0] wr_data,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic              frame_busy
);
  smi_state_t          st;
  logic [PRE_CW-1:0]   pre_cnt;
  logic [4:0]          idx;
  logic [4:0]          idx_n;
  logic [HDR_BITS-2:0] hdr_q;
  smi_hdr_t            hdr_w;
  logic                rd_sel, wr_sel;
  logic [REG_AW-1:0]   regad_q;
  logic [REG_DW-1:0]   shreg;
  logic                body_stb, hdr_done, addr_ok;

  assign idx_n    = idx + 5'd1;
  assign hdr_w    = smi_hdr_t'({hdr_q, sample_bit});
  assign body_stb = sample_stb && (st == SMI_BODY);
  assign hdr_done = body_stb && (idx_n == 5'(HDR_BITS));
  assign addr_ok  = (hdr_w.phy == phy_addr);
  assign rd_req   = hdr_done && addr_ok && (hdr_w.op == OP_RD);
  assign wr_req   = body_stb && (idx_n == 5'(BODY_BITS)) && wr_sel;
  assign reg_addr = hdr_done ? hdr_w.regad : regad_q;
  assign wr_data  = {shreg[REG_DW-2:0], sample_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SMI_PRE;
      pre_cnt <= '0;
      idx     <= '0;
      hdr_q   <= '0;
      rd_sel  <= 1'b0;
      wr_sel  <= 1'b0;
      regad_q <= '0;
      shreg   <= '0;
    end else if (sample_stb) begin
      unique case (st)
        SMI_PRE: begin
          if (sample_bit) begin
            if (pre_cnt != PRE_CW'(PRE_LEN)) pre_cnt <= pre_cnt + 1'b1;
          end else if (pre_cnt == PRE_CW'(PRE_LEN)) begin
            st <= SMI_START;
          end else begin
            pre_cnt <= '0;
          end
        end
        SMI_START: begin
          if (sample_bit) begin
            st     <= SMI_BODY;
            idx    <= '0;
            rd_sel <= 1'b0;
            wr_sel <= 1'b0;
          end else begin
            st      <= SMI_PRE;
            pre_cnt <= '0;
          end
        end
        default: begin
          idx <= idx_n;
          if (idx_n < 5'(HDR_BITS)) hdr_q <= hdr_w[HDR_BITS-2:0];
          if (hdr_done) begin
            rd_sel  <= rd_req;
            wr_sel  <= addr_ok && (hdr_w.op == OP_WR);
            regad_q <= hdr_w.regad;
          end
          if (rd_req) shreg <= rd_data;
          else if (wr_sel && idx_n >= 5'(DATA_FIRST)) shreg <= wr_data;
          if (idx_n == 5'(BODY_BITS)) begin
            st      <= SMI_PRE;
            pre_cnt <= '0;
            rd_sel  <= 1'b0;
            wr_sel  <= 1'b0;
          end
        end
      endcase
    end
  end

  assign frame_busy = (st == SMI_BODY);
  assign mdio_oe    = frame_busy && rd_sel && (idx >= 5'(TA_FIRST)) &&
                      (idx < 5'(BODY_BITS));
  assign mdio_out   = mdio_oe ? smi_drive_bit(shreg, idx) : 1'b0;
endmodule

// File: rtl/phy_irq_unit.sv
module phy_irq_unit
  import phy_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt,
  input  logic             clr,
  input  logic             mask_we,
  input  logic [EVT_W-1:0] mask_wbits,
  output logic [EVT_W-1:0] src_bits,
  output logic [EVT_W-1:0] mask_bits,
  output logic             irq
);
  // One sticky flag per event; a same-cycle event overrides the clear.
  for (genvar i = 0; i < EVT_W; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_bits[i]  <= 1'b0;
        mask_bits[i] <= 1'b0;
      end else begin
        src_bits[i] <= (src_bits[i] & ~clr) | evt[i];
        if (mask_we) mask_bits[i] <= mask_wbits[i];
      end
    end
  end

  assign irq = |(src_bits & mask_bits);
endmodule

// File: rtl/phy_reg_file.sv
module phy_reg_file
  import phy_mgmt_pkg::*;
#(
  parameter logic [REG_DW-1:0] CTRL_RST = 16'h3000,
  parameter logic [REG_DW-1:0] ADV_RST  = 16'h01E1,
  parameter logic [REG_DW-1:0] STAT_VAL = 16'h7809,
  parameter logic [REG_DW-1:0] ID_HI    = 16'h0007,
  parameter logic [REG_DW-1:0] ID_LO    = 16'hC0F1,
  parameter logic [REG_DW-1:0] LPA_VAL  = 16'h0000,
  parameter logic [REG_DW-1:0] EXP_VAL  = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic [REG_DW-1:0] src_val,
  input  logic [REG_DW-1:0] mask_val,
  output logic [REG_DW-1:0] rdata,
  output logic              mask_we
);
  logic [REG_DW-1:0] ctrl_q, adv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      adv_q  <= ADV_RST;
    end else if (wr_req) begin
      if (addr == A_CTRL) ctrl_q <= wdata;
      if (addr == A_ADV)  adv_q  <= wdata;
    end
  end

  assign mask_we = wr_req && (addr == A_IMASK);

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata = ctrl_q;
      A_STAT:  rdata = STAT_VAL;
      A_ID_HI: rdata = ID_HI;
      A_ID_LO: rdata = ID_LO;
      A_ADV:   rdata = adv_q;
      A_LPA:   rdata = LPA_VAL;
      A_EXP:   rdata = EXP_VAL;
      A_ISRC:  rdata = src_val;
      A_IMASK: rdata = mask_val;
      default: rdata = '1;
    endcase
  end
endmodule

// File: rtl/phy_mgmt_top.sv
module phy_mgmt_top
  import phy_mgmt_pkg::*;
#(
  parameter logic [REG_DW-1:0] CTRL_RST = 16'h3000,
  parameter logic [REG_DW-1:0] ADV_RST  = 16'h01E1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc,
  input  logic              mdio_in,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic [REG_AW-1:0] phy_addr,
  input  logic [EVT_W-1:0]  event_pulse,
  output logic              irq
);
  logic              sample_stb, sample_bit;
  logic              smi_rd_req, smi_wr_req, frame_busy;
  logic [REG_AW-1:0] smi_reg_addr;
  logic [REG_DW-1:0] smi_wr_data, reg_rdata;
  logic              src_clr, mask_we;
  logic [EVT_W-1:0]  src_bits, mask_bits;
  logic [REG_DW-1:0] src_val, mask_val;

  phy_mdc_sync u_sync (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(mdio_in),
    .sample_stb(sample_stb), .sample_bit(sample_bit)
  );

  phy_smi_slave u_smi (
    .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr),
    .sample_stb(sample_stb), .sample_bit(sample_bit), .rd_data(reg_rdata),
    .rd_req(smi_rd_req), .wr_req(smi_wr_req), .reg_addr(smi_reg_addr),
    .wr_data(smi_wr_data), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .frame_busy(frame_busy)
  );

  assign src_clr  = smi_rd_req && (smi_reg_addr == A_ISRC);
  assign src_val  = flags_to_reg(src_bits);
  assign mask_val = flags_to_reg(mask_bits);

  phy_reg_file #(.CTRL_RST(CTRL_RST), .ADV_RST(ADV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_req(smi_wr_req), .addr(smi_reg_addr),
    .wdata(smi_wr_data), .src_val(src_val), .mask_val(mask_val),
    .rdata(reg_rdata), .mask_we(mask_we)
  );

  phy_irq_unit u_irq (
    .clk(clk), .rst_n(rst_n), .evt(event_pulse), .clr(src_clr),
    .mask_we(mask_we), .mask_wbits(smi_wr_data[EVT_W:1]),
    .src_bits(src_bits), .mask_bits(mask_bits), .irq(irq)
  );
endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk
  import phy_mgmt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mdio_oe,
  input logic              frame_busy,
  input logic              irq,
  input logic [EVT_W-1:0]  event_pulse,
  input logic              src_clr,
  input logic              smi_wr_req,
  input logic [REG_AW-1:0] smi_reg_addr,
  input logic [REG_DW-1:0] src_val,
  input logic [REG_DW-1:0] mask_val
);
  // R9: an event on the clearing edge survives the clear
  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (src_clr && event_pulse != '0) |=> src_val == $past(flags_to_reg(event_pulse)));

  // R8: a clear with no event empties the flags and drops irq
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (src_clr && event_pulse == '0) |=> (src_val == '0 && !irq));

  // R7: flags are sticky without a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !src_clr |=> ((src_val & $past(src_val)) == $past(src_val)));

  // R7 / R10: unused positions read zero
  a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (src_val[0] == 1'b0 && src_val[REG_DW-1:EVT_W+1] == '0 &&
     mask_val[0] == 1'b0 && mask_val[REG_DW-1:EVT_W+1] == '0));

  // R11: nothing enabled, no interrupt
  a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_val == '0) |-> !irq);

  // R12: writing the source register changes nothing
  a_r12_src_write: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_wr_req && smi_reg_addr == A_ISRC && event_pulse == '0 && !src_clr)
      |=> $stable(src_val));

  // R3 / R4: MDIO is only driven inside a frame body
  a_r3_drive_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> frame_busy);
endmodule

bind phy_mgmt_top phy_mgmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdio_oe(mdio_oe), .frame_busy(frame_busy),
  .irq(irq), .event_pulse(event_pulse), .src_clr(src_clr),
  .smi_wr_req(smi_wr_req), .smi_reg_addr(smi_reg_addr),
  .src_val(src_val), .mask_val(mask_val)
);

// File: tb/phy_mgmt_top_tb.sv
module phy_mgmt_top_tb;
  localparam logic [4:0] STRAP = 5'd9;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdc = 1'b0;
  logic host_oe = 1'b1;
  logic host_bit = 1'b1;
  logic [6:0] event_pulse = '0;
  logic mdio_out, mdio_oe, irq, mdio_bus;
  int n_chk = 0, n_fail = 0, oe_cnt = 0;

  logic [15:0] ctrl_m = 16'h3000, adv_m = 16'h01E1;
  logic [6:0]  src_m = '0, mask_m = '0;

  always #5 clk = ~clk;

  assign mdio_bus = mdio_oe ? mdio_out : (host_oe ? host_bit : 1'b1);

  phy_mgmt_top u_dut (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(mdio_bus),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .phy_addr(STRAP),
    .event_pulse(event_pulse), .irq(irq)
  );

  always @(negedge clk) if (mdio_oe) oe_cnt++;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_reg(input logic [4:0] a);
    case (a)
      5'd0: return ctrl_m;
      5'd1: return 16'h7809;
      5'd2: return 16'h0007;
      5'd3: return 16'hC0F1;
      5'd4: return adv_m;
      5'd5, 5'd6: return 16'h0000;
      5'd29: return {8'h00, src_m, 1'b0};
      5'd30: return {8'h00, mask_m, 1'b0};
      default: return 16'hFFFF;
    endcase
  endfunction

  // One MDC period driving bit b; optional event timed onto the third clock after rise.
  task automatic host_bit_cycle(input logic b, input logic [6:0] hit);
    @(negedge clk); mdc = 1'b0; host_oe = 1'b1; host_bit = b;
    repeat (HALF) @(negedge clk);
    mdc = 1'b1;
    if (hit != '0) begin
      repeat (2) @(negedge clk); event_pulse = hit;
      @(negedge clk); event_pulse = '0;
      repeat (HALF - 4) @(negedge clk);
    end else begin
      repeat (HALF - 1) @(negedge clk);
    end
  endtask

  // Released-bus MDC period; returns bus value and oe seen just before the rise.
  task automatic host_listen(output logic v, output logic oe);
    @(negedge clk); mdc = 1'b0; host_oe = 1'b0;
    repeat (HALF) @(negedge clk);
    v = mdio_bus; oe = mdio_oe;
    mdc = 1'b1;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic smi_frame(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [6:0] hit,
                           output logic [15:0] rd, output logic ta_ok);
    logic v, oe;
    logic [11:0] hdr;
    hdr = {op, pa, ra};
    ta_ok = 1'b1;
    rd = '0;
    for (int i = 0; i < 32; i++) host_bit_cycle(1'b1, '0);
    host_bit_cycle(1'b0, '0);
    host_bit_cycle(1'b1, '0);
    for (int i = 11; i >= 0; i--) host_bit_cycle(hdr[i], (i == 0) ? hit : 7'h00);
    if (op == 2'b10) begin
      host_listen(v, oe); if (oe) ta_ok = 1'b0;
      host_listen(v, oe); if (pa == STRAP && (v !== 1'b0 || !oe)) ta_ok = 1'b0;
      for (int i = 15; i >= 0; i--) begin
        host_listen(v, oe); rd[i] = v;
      end
    end else begin
      host_bit_cycle(1'b1, '0);
      host_bit_cycle(1'b0, '0);
      for (int i = 15; i >= 0; i--) host_bit_cycle(wd[i], '0);
    end
    host_bit_cycle(1'b1, '0);
    host_bit_cycle(1'b1, '0);
  endtask

  task automatic do_read(input string req, input logic [4:0] ra, input logic [6:0] hit);
    logic [15:0] rd; logic ta;
    logic [15:0] e;
    e = exp_reg(ra);
    smi_frame(2'b10, STRAP, ra, 16'h0, hit, rd, ta);
    chk(req, rd, e);
    chk({req, " turnaround (R3)"}, {15'h0, ta}, 16'h1);
    if (ra == 5'd29) src_m = hit;
  endtask

  task automatic do_write(input logic [4:0] ra, input logic [15:0] wd);
    logic [15:0] rd; logic ta;
    smi_frame(2'b01, STRAP, ra, wd, '0, rd, ta);
    if (ra == 5'd0) ctrl_m = wd;
    if (ra == 5'd4) adv_m = wd;
    if (ra == 5'd30) mask_m = wd[7:1];
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk); event_pulse = e;
    @(negedge clk); event_pulse = '0;
    src_m = src_m | e;
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_irq(input string req);
    @(negedge clk);
    chk(req, {15'h0, irq}, {15'h0, |(src_m & mask_m)});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] rd; logic ta;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {15'h0, irq}, 16'h0);
    chk("R1 oe", {15'h0, mdio_oe}, 16'h0);

    // R5 R6 R7 R10 sweep of every address
    for (int a = 0; a < 32; a++) do_read("R2 R5 R6 R10 sweep", 5'(a), '0);

    // R5 writable and read-only registers
    do_write(5'd0, 16'h1234); do_read("R5 ctrl write", 5'd0, '0);
    do_write(5'd4, 16'hA5A5); do_read("R5 adv write", 5'd4, '0);
    do_write(5'd1, 16'h0000); do_read("R5 status ro", 5'd1, '0);
    do_write(5'd3, 16'h1111); do_read("R5 id ro", 5'd3, '0);
    // R6 unsupported write then read
    do_write(5'd12, 16'h0000); do_read("R6 unsupported", 5'd12, '0);
    do_read("R6 addr31", 5'd31, '0);

    // R4 foreign address: no write, no drive
    smi_frame(2'b01, STRAP ^ 5'd1, 5'd0, 16'hFFFF, '0, rd, ta);
    oe_cnt = 0;
    smi_frame(2'b10, STRAP ^ 5'd4, 5'd1, 16'h0, '0, rd, ta);
    chk("R4 no drive", 16'(oe_cnt), 16'h0);
    do_read("R4 ctrl untouched", 5'd0, '0);

    // R2 bad opcodes
    smi_frame(2'b11, STRAP, 5'd0, 16'h0F0F, '0, rd, ta);
    smi_frame(2'b00, STRAP, 5'd4, 16'h0F0F, '0, rd, ta);
    do_read("R2 op11 ignored", 5'd0, '0);
    do_read("R2 op00 ignored", 5'd4, '0);

    // R7 R8 R11 each event with mask clear
    for (int i = 0; i < 7; i++) begin
      pulse(7'(1 << i));
      chk_irq("R11 masked off");
      do_read("R7 R8 source set", 5'd29, '0);
      do_read("R8 source cleared", 5'd29, '0);
    end

    // R10 mask write
    do_write(5'd30, 16'hFFFF); do_read("R10 mask bits", 5'd30, '0);
    pulse(7'h04);
    chk_irq("R11 enabled raises");
    // R12 write to source ignored
    do_write(5'd29, 16'h0000);
    chk_irq("R12 irq kept");
    do_read("R12 R8 source after write", 5'd29, '0);
    chk_irq("R8 irq dropped");

    // R11 selective mask
    do_write(5'd30, 16'h0002);
    pulse(7'h10);
    chk_irq("R11 other bit masked");
    pulse(7'h01);
    chk_irq("R11 enabled bit");
    do_read("R8 clear mixed", 5'd29, '0);
    chk_irq("R11 after clear");

    // R9 collision: event on the clearing edge survives
    do_read("R9 collide empty", 5'd29, 7'h10);
    do_read("R9 kept flag", 5'd29, '0);
    pulse(7'h01);
    do_read("R9 collide set", 5'd29, 7'h04);
    do_read("R9 kept flag 2", 5'd29, '0);
    chk_irq("R11 final");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule